// File: doc/BRIEF.md
# Fused-Operation Integer ALU

This block is a purely combinational 64-bit integer execution unit for compound micro-ops. A decoder upstream merges certain pairs of simple instructions (a shift followed by an add, a word add followed by a narrowing mask, and similar pairs) into one internal operation. This unit then produces, in the same cycle, exactly the value the original pair would have left in its destination register. That includes the word-width rules: sign extension from bit 31 and truncation to 32 bits.

The caller presents two 64-bit source operands, a 5-bit operation code and a valid strobe. The unit returns the 64-bit result together with a result-valid strobe. It also returns an illegal-operation flag for any code outside the defined set. There is no pipeline register, so the result-valid output is the input strobe passed straight through.

Top module: `fuse_alu`

## Requirements
- R1: Codes 0, 1, 2 and 3 return (src_a shifted left by code+1) + src_b, wrapping modulo 2^64.
- R2: Codes 4, 5, 6 and 7 return (src_a logically shifted right by 25+code) + src_b, wrapping modulo 2^64. The shift amounts are therefore 29, 30, 31 and 32.
- R3: Codes 8, 9 and 10 zero-extend src_a[31:0] to 64 bits and shift it left by code-7. This equals a left shift by 32 followed by a logical right shift by 39-code.
- R4: Code 11 returns src_a[15:8] in bits 7:0, with every other bit zero.
- R5: Code 12 returns (src_a AND 1) + src_b as a 64-bit wrapping sum.
- R6: Code 13 forms the 32-bit sum (src_a[0] + src_b[31:0]) and returns it sign-extended from its bit 31.
- R7: Code 14 returns {src_a[63:8], 8'h00} OR src_b.
- R8: Let W be the 32-bit sum src_a[31:0] + src_b[31:0]. Code 15 returns W[7:0] zero-extended. Code 16 returns W[0] in bit 0, with every other bit zero.
- R9: Code 17 returns W[15:0] zero-extended. Code 18 returns W[15:0] sign-extended from bit 15.
- R10: Codes 19 to 31 return a zero result. They drive out_illegal high whenever in_valid is high.
- R11: out_valid equals in_valid in the same cycle. out_illegal is low whenever in_valid is low, and also for codes 0 to 18.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| in_valid | input | 1 | Operation request strobe |
| op_code | input | 5 | Fused operation code (0 to 18 defined) |
| src_a | input | 64 | First source operand |
| src_b | input | 64 | Second source operand |
| out_valid | output | 1 | Result strobe, same cycle as in_valid |
| out_result | output | 64 | Operation result, zero for undefined codes |
| out_illegal | output | 1 | High for a valid request with an undefined code |

## Verification
The unit holds no state, so a decode or datapath fault shows at out_result in the very cycle the faulty code is presented. It then disappears as soon as the code changes. A code steered to the wrong sub-unit shows up as a zero result or a wrong value on that code alone. A wrong shift constant shows up only with operands whose bits cross the shifted boundary. The corner operands (all ones, 0x8000_0000, 0xFF) are chosen so that carries, the sign bit at 31 and the sign bit at 15 all flip across the cases. A fault in the strobe path shows as out_valid or out_illegal disagreeing with in_valid on the same edge.

// File: rtl/fuse_alu_pkg.sv
// Package: shared widths and the operation code map of the fused ALU.
// Assumes a 64-bit datapath with 32-bit word and 16-bit half operations.
package fuse_alu_pkg;

    localparam int XLEN     = 64;
    localparam int WLEN     = 32;
    localparam int HLEN     = 16;
    localparam int OPW      = 5;
    localparam int NUM_OPS  = 19;

    typedef enum logic [OPW-1:0] {
        OP_SHL1_ADD   = 5'd0,
        OP_SHL2_ADD   = 5'd1,
        OP_SHL3_ADD   = 5'd2,
        OP_SHL4_ADD   = 5'd3,
        OP_SHR29_ADD  = 5'd4,
        OP_SHR30_ADD  = 5'd5,
        OP_SHR31_ADD  = 5'd6,
        OP_SHR32_ADD  = 5'd7,
        OP_ZW_SHL1    = 5'd8,
        OP_ZW_SHL2    = 5'd9,
        OP_ZW_SHL3    = 5'd10,
        OP_BYTE1      = 5'd11,
        OP_LSB_ADD    = 5'd12,
        OP_LSB_ADDW   = 5'd13,
        OP_HIMASK_OR  = 5'd14,
        OP_WADD_BYTE  = 5'd15,
        OP_WADD_BIT   = 5'd16,
        OP_WADD_ZEXTH = 5'd17,
        OP_WADD_SEXTH = 5'd18
    } fuse_op_e;

endpackage

// File: rtl/fuse_shadd_unit.sv
// Module: shift-then-add family (R1, R2).
// Builds every left and right pre-shifted copy of src_a in a generate loop,
// picks one by op code and adds src_b. Result is zero when the code is not ours.
// Assumes consecutive op codes for each shift direction.
module fuse_shadd_unit
    import fuse_alu_pkg::*;
#(
    parameter int XLEN       = fuse_alu_pkg::XLEN,
    parameter int NSHIFT     = 4,
    parameter int LEFT_BASE  = 1,
    parameter int RIGHT_BASE = 29
) (
    input  logic [OPW-1:0]  op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] res,
    output logic            hit
);

    localparam int LEFT_CODE  = int'(OP_SHL1_ADD);
    localparam int RIGHT_CODE = int'(OP_SHR29_ADD);

    logic [XLEN-1:0] left_t  [NSHIFT];
    logic [XLEN-1:0] right_t [NSHIFT];
    logic [XLEN-1:0] addend;

    for (genvar i = 0; i < NSHIFT; i++) begin : g_shift
        assign left_t[i]  = a << (LEFT_BASE + i);
        assign right_t[i] = a >> (RIGHT_BASE + i);
    end

    // Select the pre-shifted operand that matches the op code.
    always_comb begin
        addend = '0;
        hit    = 1'b0;
        for (int i = 0; i < NSHIFT; i++) begin
            if (op == OPW'(LEFT_CODE + i)) begin
                addend = left_t[i];
                hit    = 1'b1;
            end
            if (op == OPW'(RIGHT_CODE + i)) begin
                addend = right_t[i];
                hit    = 1'b1;
            end
        end
    end

    // Single shared 64-bit adder, gated so a miss contributes zero.
    always_comb begin
        res = hit ? (addend + b) : '0;
    end

endmodule

// File: rtl/fuse_bitfield_unit.sv
// Module: full-width field operations (R3, R4, R5, R7).
// Zero-extended word shifts, second-byte extract, low-bit add and high-mask OR.
// Result is zero when the code is not one of these.
module fuse_bitfield_unit
    import fuse_alu_pkg::*;
#(
    parameter int XLEN   = fuse_alu_pkg::XLEN,
    parameter int WLEN   = fuse_alu_pkg::WLEN,
    parameter int NZW    = 3
) (
    input  logic [OPW-1:0]  op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] res,
    output logic            hit
);

    localparam int ZW_CODE  = int'(OP_ZW_SHL1);
    localparam int BYTE_LO  = 8;
    localparam int BYTE_HI  = 15;
    localparam int MASK_LSB = 8;

    logic [XLEN-1:0] zw_base;
    logic [XLEN-1:0] zw_t [NZW];
    logic [XLEN-1:0] byte_v;
    logic [XLEN-1:0] lsb_sum;
    logic [XLEN-1:0] mask_or;

    assign zw_base = {{(XLEN-WLEN){1'b0}}, a[WLEN-1:0]};

    for (genvar i = 0; i < NZW; i++) begin : g_zw
        assign zw_t[i] = zw_base << (i + 1);
    end

    // Byte extract, low-bit add and masked OR datapaths.
    always_comb begin
        byte_v  = {{(XLEN-(BYTE_HI-BYTE_LO+1)){1'b0}}, a[BYTE_HI:BYTE_LO]};
        lsb_sum = {{(XLEN-1){1'b0}}, a[0]} + b;
        mask_or = {a[XLEN-1:MASK_LSB], {MASK_LSB{1'b0}}} | b;
    end

    // Pick the result for the active op code.
    always_comb begin
        res = '0;
        hit = 1'b1;
        case (op)
            OP_BYTE1:     res = byte_v;
            OP_LSB_ADD:   res = lsb_sum;
            OP_HIMASK_OR: res = mask_or;
            default: begin
                hit = 1'b0;
                for (int i = 0; i < NZW; i++) begin
                    if (op == OPW'(ZW_CODE + i)) begin
                        res = zw_t[i];
                        hit = 1'b1;
                    end
                end
            end
        endcase
    end

endmodule

// File: rtl/fuse_word_unit.sv
// Module: word-width operations (R6, R8, R9).
// The narrowing ops need only the low 16 bits of the 32-bit word sum, so a
// 16-bit adder serves them; the word low-bit add uses its own 32-bit adder.
// Result is zero when the code is not one of these.
module fuse_word_unit
    import fuse_alu_pkg::*;
#(
    parameter int XLEN = fuse_alu_pkg::XLEN,
    parameter int WLEN = fuse_alu_pkg::WLEN,
    parameter int HLEN = fuse_alu_pkg::HLEN
) (
    input  logic [OPW-1:0]  op,
    input  logic [HLEN-1:0] a_half,
    input  logic            a_lsb,
    input  logic [WLEN-1:0] b_word,
    output logic [XLEN-1:0] res,
    output logic            hit
);

    logic [HLEN-1:0] half_sum;
    logic [WLEN-1:0] lsb_word;

    // Low half of the word sum and the word low-bit sum.
    always_comb begin
        half_sum = a_half + b_word[HLEN-1:0];
        lsb_word = {{(WLEN-1){1'b0}}, a_lsb} + b_word;
    end

    // Narrow or extend according to the op code.
    always_comb begin
        res = '0;
        hit = 1'b1;
        case (op)
            OP_LSB_ADDW:   res = {{(XLEN-WLEN){lsb_word[WLEN-1]}}, lsb_word};
            OP_WADD_BYTE:  res = {{(XLEN-8){1'b0}}, half_sum[7:0]};
            OP_WADD_BIT:   res = {{(XLEN-1){1'b0}}, half_sum[0]};
            OP_WADD_ZEXTH: res = {{(XLEN-HLEN){1'b0}}, half_sum};
            OP_WADD_SEXTH: res = {{(XLEN-HLEN){half_sum[HLEN-1]}}, half_sum};
            default:       hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/fuse_alu.sv
// Module: top of the fused-operation ALU.
// Fans the operands out to three sub-units; each returns zero unless it owns
// the code, so the results merge with an OR. Purely combinational: no state,
// no latency, no reset needed.
module fuse_alu
    import fuse_alu_pkg::*;
#(
    parameter int XLEN = fuse_alu_pkg::XLEN
) (
    input  logic            in_valid,
    input  logic [4:0]      op_code,
    input  logic [63:0]     src_a,
    input  logic [63:0]     src_b,
    output logic            out_valid,
    output logic [63:0]     out_result,
    output logic            out_illegal
);

    logic [XLEN-1:0] res_sa, res_bf, res_wd;
    logic            hit_sa, hit_bf, hit_wd;

    fuse_shadd_unit #(.XLEN(XLEN)) u_shadd (
        .op  (op_code),
        .a   (src_a),
        .b   (src_b),
        .res (res_sa),
        .hit (hit_sa)
    );

    fuse_bitfield_unit #(.XLEN(XLEN)) u_bitfield (
        .op  (op_code),
        .a   (src_a),
        .b   (src_b),
        .res (res_bf),
        .hit (hit_bf)
    );

    fuse_word_unit #(.XLEN(XLEN)) u_word (
        .op     (op_code),
        .a_half (src_a[HLEN-1:0]),
        .a_lsb  (src_a[0]),
        .b_word (src_b[WLEN-1:0]),
        .res    (res_wd),
        .hit    (hit_wd)
    );

    // Merge sub-unit results and derive the strobes.
    always_comb begin
        out_result  = res_sa | res_bf | res_wd;
        out_valid   = in_valid;
        out_illegal = in_valid & ~(hit_sa | hit_bf | hit_wd);
    end

endmodule

// File: rtl/fuse_alu_checker.sv
// Module: property checker for fuse_alu, bound into every instance.
// The block is combinational, so the checks are immediate assertions that are
// evaluated whenever the ports settle.
module fuse_alu_checker (
    input logic        in_valid,
    input logic [4:0]  op_code,
    input logic [63:0] src_a,
    input logic [63:0] src_b,
    input logic        out_valid,
    input logic [63:0] out_result,
    input logic        out_illegal
);

    // Strobe and flag relations.
    always_comb begin
        assert_valid_follow_R11: assert (out_valid == in_valid)
            else $error("out_valid differs from in_valid");
        if (!in_valid) begin
            assert_illegal_gated_R11: assert (!out_illegal)
                else $error("illegal flag without request");
        end
        if (out_illegal) begin
            assert_illegal_zero_R10: assert (out_result == 64'd0)
                else $error("illegal code gave nonzero result");
        end
    end

    // Width and extension shape of the results.
    always_comb begin
        if (op_code == 5'd16) begin
            assert_bit_narrow_R8: assert (out_result[63:1] == 63'd0)
                else $error("bit result wider than one bit");
        end
        if (op_code == 5'd11) begin
            assert_byte_narrow_R4: assert (out_result[63:8] == 56'd0)
                else $error("byte result wider than a byte");
        end
        if (op_code == 5'd18) begin
            assert_sext_shape_R9: assert (out_result[63:15] == 49'd0 || out_result[63:15] == {49{1'b1}})
                else $error("half sign extension broken");
        end
        if (op_code == 5'd13) begin
            assert_wsext_shape_R6: assert (out_result[63:32] == {32{out_result[31]}})
                else $error("word sign extension broken");
        end
        if (op_code == 5'd14) begin
            assert_or_cover_R7: assert (((out_result[63:8] & src_a[63:8]) == src_a[63:8]) && (out_result[7:0] == src_b[7:0]))
                else $error("masked OR lost bits");
        end
    end

endmodule

bind fuse_alu fuse_alu_checker u_chk (
    .in_valid    (in_valid),
    .op_code     (op_code),
    .src_a       (src_a),
    .src_b       (src_b),
    .out_valid   (out_valid),
    .out_result  (out_result),
    .out_illegal (out_illegal)
);

// File: tb/fuse_alu_test.sv
// Directed bench for fuse_alu: one task per scenario, each checking its results.
module fuse_alu_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [4:0]  op_code = 5'd0;
    logic [63:0] src_a = 64'd0;
    logic [63:0] src_b = 64'd0;
    logic        out_valid;
    logic [63:0] out_result;
    logic        out_illegal;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    fuse_alu uut (
        .in_valid    (in_valid),
        .op_code     (op_code),
        .src_a       (src_a),
        .src_b       (src_b),
        .out_valid   (out_valid),
        .out_result  (out_result),
        .out_illegal (out_illegal)
    );

    // Reference: the value the original instruction pair would leave.
    function automatic logic [63:0] model(input logic [4:0] op, input logic [63:0] a, input logic [63:0] b);
        logic [63:0] t;
        logic [31:0] w;
        w = a[31:0] + b[31:0];
        case (op)
            5'd0, 5'd1, 5'd2, 5'd3: model = (a << (op + 1)) + b;
            5'd4, 5'd5, 5'd6, 5'd7: model = (a >> (op + 25)) + b;
            5'd8, 5'd9, 5'd10:      model = (a << 32) >> (39 - op);
            5'd11: model = (a >> 8) & 64'hFF;
            5'd12: model = (a & 64'd1) + b;
            5'd13: begin
                t = (a & 64'd1) + b;
                model = {{32{t[31]}}, t[31:0]};
            end
            5'd14: model = (a & 64'hFFFF_FFFF_FFFF_FF00) | b;
            5'd15: model = {{32{w[31]}}, w} & 64'hFF;
            5'd16: model = {{32{w[31]}}, w} & 64'h1;
            5'd17: model = {{32{w[31]}}, w} & 64'hFFFF;
            5'd18: model = {{48{w[15]}}, w[15:0]};
            default: model = 64'd0;
        endcase
    endfunction

    task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Drive one request between edges and compare all outputs.
    task automatic run_op(input string req, input logic [4:0] op, input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        op_code  = op;
        src_a    = a;
        src_b    = b;
        #2;
        check(req, $sformatf("result op %0d", op), out_result, model(op, a, b));
        check(req, "illegal flag", {63'd0, out_illegal}, {63'd0, (op > 5'd18)});
        check("R11", "valid strobe", {63'd0, out_valid}, 64'd1);
    endtask

    task automatic sweep(input string req, input logic [4:0] lo, input logic [4:0] hi);
        logic [63:0] corner [5];
        corner[0] = 64'hFFFF_FFFF_FFFF_FFFF;
        corner[1] = 64'h0000_0000_8000_0000;
        corner[2] = 64'h0000_0000_0000_00FF;
        corner[3] = 64'd0;
        corner[4] = 64'h0000_0000_0000_7FFF;
        for (int op = int'(lo); op <= int'(hi); op++) begin
            for (int i = 0; i < 5; i++) begin
                for (int j = 0; j < 5; j++) begin
                    run_op(req, 5'(op), corner[i], corner[j]);
                end
            end
            for (int k = 0; k < 20; k++) begin
                run_op(req, 5'(op), {$urandom, $urandom}, {$urandom, $urandom});
            end
        end
    endtask

    task automatic test_reset;
        @(negedge clk);
        #2;
        check("R11", "idle valid during reset", {63'd0, out_valid}, 64'd0);
        check("R11", "idle illegal during reset", {63'd0, out_illegal}, 64'd0);
    endtask

    task automatic test_shift_add;
        sweep("R1", 5'd0, 5'd3);
        sweep("R2", 5'd4, 5'd7);
        run_op("R2", 5'd7, 64'hFFFF_FFFF_0000_0000, 64'd1);
    endtask

    task automatic test_zext_word;
        sweep("R3", 5'd8, 5'd10);
        run_op("R3", 5'd10, 64'hDEAD_BEEF_FFFF_FFFF, 64'd0);
    endtask

    task automatic test_byte;
        sweep("R4", 5'd11, 5'd11);
        run_op("R4", 5'd11, 64'h1234_5678_9ABC_A5EF, 64'hFFFF);
    endtask

    task automatic test_low_bit;
        sweep("R5", 5'd12, 5'd12);
        sweep("R6", 5'd13, 5'd13);
        run_op("R6", 5'd13, 64'd1, 64'h0000_0000_7FFF_FFFF);
    endtask

    task automatic test_mask_or;
        sweep("R7", 5'd14, 5'd14);
    endtask

    task automatic test_word_narrow;
        sweep("R8", 5'd15, 5'd16);
        sweep("R9", 5'd17, 5'd18);
        run_op("R9", 5'd18, 64'h0000_0000_0000_7FFF, 64'd1);
        run_op("R8", 5'd16, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2);
    endtask

    task automatic test_illegal;
        sweep("R10", 5'd19, 5'd31);
    endtask

    task automatic test_valid_gating;
        for (int op = 0; op < 32; op += 7) begin
            @(negedge clk);
            in_valid = 1'b0;
            op_code  = 5'(op);
            src_a    = 64'hFFFF_FFFF_FFFF_FFFF;
            src_b    = 64'h1;
            #2;
            check("R11", "valid low", {63'd0, out_valid}, 64'd0);
            check("R11", "illegal low when idle", {63'd0, out_illegal}, 64'd0);
        end
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Scenario sequence.
    initial begin
        test_reset;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        test_shift_add;
        test_zext_word;
        test_byte;
        test_low_bit;
        test_mask_or;
        test_word_narrow;
        test_illegal;
        test_valid_gating;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule